// File: doc/BRIEF.md
# CAN Interrupt Status and Capture Word

This block gathers event and status signals from a CAN controller core and turns them into one 32-bit status word that a bus master reads. Some flags follow a condition directly. Others latch on an edge or on a qualified level and stay set until the word is read. Two capture bytes record the most recent bus-error code and the bit position where arbitration was lost. Each byte freezes on its first event and ignores later ones until the word is read. Every flag bit is ORed into one interrupt request.

A read is signalled by `rd_en` being high for one clock. During that cycle `rd_data` shows the contents from before the read. The side effects of the read take hold at the following clock edge: the sticky flags clear and both capture bytes re-arm. An interrupt-enable vector gates each flag. Bit k of `int_en` enables flag bit k, for k = 0 to 7. The error-passive state, the error counters and the protocol engine all live outside this block.

Top module: `can_irq_capture`

## Requirements
- R1: While reset is active, and after it, until any event, `rd_data` is 0 and `irq` is 0. Both capture bytes start armed. The previous-value registers used for edge detection start at 0.
- R2: Bit 0 equals `rx_buf_full & int_en[0]` in the same cycle. A read does not clear it.
- R3: Bit 1 is set at the clock edge after `tx_buf1_free` goes from 0 to 1 while `int_en[1]` is 1.
- R4: Bit 2 is set at the clock edge after any change, rising or falling, of `err_warn` or `bus_off`, if `int_en[2]` is 1 in the cycle of the change.
- R5: Bit 3 is set at the clock edge after `overrun` goes from 0 to 1 while `int_en[3]` is 1.
- R6: Bit 4 is set at the clock edge after a cycle in which `sleeping`, `bus_activity` and `int_en[4]` are all 1.
- R7: Bit 5 is set at the clock edge after `err_passive` changes in either direction while `int_en[5]` is 1.
- R8: When `bus_err` is 1, bits 23:16 load `bus_err_code` if that byte is armed. Bit 7 is set if `int_en[7]` is 1.
- R9: When `arb_lost` is 1, bits 31:24 load `arb_lost_pos` if that byte is armed. Bit 6 is set if `int_en[6]` is 1.
- R10: A loaded capture byte keeps its value while further events arrive. Only a read re-arms it, and the read leaves its value in place.
- R11: Any read clears bits 1 to 10 at the next edge. Bits 8 to 15 always read 0.
- R12: A qualifying event in the same cycle as a read wins. The flag is set after the edge, and an event on a capture byte loads the new value and leaves the byte disarmed.
- R13: `irq` equals the OR of bits 0 to 10 of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe for the status word |
| rx_buf_full | input | 1 | Receive buffer holds a message |
| tx_buf1_free | input | 1 | Transmit buffer 1 is available |
| err_warn | input | 1 | Error warning status |
| bus_off | input | 1 | Bus status |
| overrun | input | 1 | Data overrun status |
| sleeping | input | 1 | Controller is in sleep mode |
| bus_activity | input | 1 | Bus activity detected |
| err_passive | input | 1 | Controller is error passive |
| bus_err | input | 1 | Bus error event strobe |
| bus_err_code | input | 8 | Error code for the bus error |
| arb_lost | input | 1 | Arbitration lost event strobe |
| arb_lost_pos | input | 8 | Bit position where arbitration was lost |
| int_en | input | 8 | Per-flag enables for bits 0 to 7 |
| rd_data | output | 32 | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
Directed patterns drive each source on its own. They hold a level source steady so that edge-triggered flags can be told apart from level-triggered ones. They toggle the two-edge sources in both directions. They toggle a source with its enable low, to show the enable is sampled in the cycle of the change. Back-to-back bus errors carrying different codes show whether the capture byte freezes or keeps following the input. A read issued in the same cycle as an event shows whether the read can swallow that event. A long random phase then mixes sparse events, random reads and changing enables, to expose interactions the directed cases miss.

// File: rtl/can_icr_pkg.sv
// Shared bit positions and widths for the CAN interrupt/capture word.
package can_icr_pkg;
    localparam int BIT_RI   = 0;   // level receive flag
    localparam int BIT_TI   = 1;   // transmit buffer 1 freed
    localparam int BIT_EW   = 2;   // error/bus status changed
    localparam int BIT_DO   = 3;   // data overrun
    localparam int BIT_WU   = 4;   // wake-up
    localparam int BIT_EP   = 5;   // error-passive transition
    localparam int BIT_AL   = 6;   // arbitration lost
    localparam int BIT_BE   = 7;   // bus error
    localparam int FLAG_TOP = 10;  // highest read-clear flag
    localparam int EN_W     = 8;   // enable vector width
    localparam int CAP_W    = 8;   // capture byte width
    localparam int WORD_W   = 32;
    localparam int ZERO_W   = WORD_W - 2*CAP_W - FLAG_TOP - 1;

    // indices into the edge-detected source vector
    localparam int SRC_TX = 0;
    localparam int SRC_EW = 1;
    localparam int SRC_BO = 2;
    localparam int SRC_OV = 3;
    localparam int SRC_EP = 4;
    localparam int SRC_N  = 5;
endpackage

// File: rtl/can_icr_edges.sv
// Edge detector bank.
// Registers the previous value of each source and reports rising and
// falling transitions. Assumes the sources are synchronous to clk;
// the previous value resets to 0.
module can_icr_edges #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    // track last-cycle value of every source
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig;
    end

    // transitions relative to the registered copy
    always_comb begin
        rise = sig & ~prev_q;
        fall = ~sig & prev_q;
    end
endmodule

// File: rtl/can_icr_flags.sv
// Sticky flag bank with clear-on-read.
// Each flag sets on its request and clears when clr is high. A set
// request in the same cycle as clr wins, so no event is lost.
module can_icr_flags #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // one sticky bit: set has priority over read clear
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/can_icr_capture.sv
// Freeze-on-first-event capture byte.
// Loads the code when an event arrives while armed, then holds it.
// A read re-arms the byte without clearing its value. An event in the
// read cycle loads the code even when disarmed and leaves it disarmed.
module can_icr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic [W-1:0] code,
    input  logic         rd,
    output logic [W-1:0] val,
    output logic         armed
);
    logic load;

    // accept the event when armed or when a read releases the byte now
    always_comb load = evt && (armed || rd);

    // capture register and arming state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val   <= '0;
            armed <= 1'b1;
        end else if (load) begin
            val   <= code;
            armed <= 1'b0;
        end else if (rd) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/can_irq_capture.sv
// Interrupt status and capture word for a CAN controller.
// Combines a level receive flag, sticky edge/level flags 1..10 that
// clear on any read, and two capture bytes into one 32-bit word with
// a combined interrupt. Assumes every input is synchronous to clk and
// that rd_en is high for one cycle per read.
module can_irq_capture
    import can_icr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic                rx_buf_full,
    input  logic                tx_buf1_free,
    input  logic                err_warn,
    input  logic                bus_off,
    input  logic                overrun,
    input  logic                sleeping,
    input  logic                bus_activity,
    input  logic                err_passive,
    input  logic                bus_err,
    input  logic [CAP_W-1:0]    bus_err_code,
    input  logic                arb_lost,
    input  logic [CAP_W-1:0]    arb_lost_pos,
    input  logic [EN_W-1:0]     int_en,
    output logic [WORD_W-1:0]   rd_data,
    output logic                irq
);
    logic [SRC_N-1:0]    src, src_rise, src_fall;
    logic [FLAG_TOP:1]   set_req;
    logic [FLAG_TOP:1]   flags_q;
    logic [CAP_W-1:0]    be_val, al_val;
    logic                be_armed, al_armed;
    logic                ri;

    // gather edge-detected sources
    always_comb begin
        src         = '0;
        src[SRC_TX] = tx_buf1_free;
        src[SRC_EW] = err_warn;
        src[SRC_BO] = bus_off;
        src[SRC_OV] = overrun;
        src[SRC_EP] = err_passive;
    end

    can_icr_edges #(.W(SRC_N)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (src),
        .rise (src_rise),
        .fall (src_fall)
    );

    // qualify each event with its enable bit
    always_comb begin
        set_req         = '0;
        set_req[BIT_TI] = src_rise[SRC_TX] & int_en[BIT_TI];
        set_req[BIT_EW] = (src_rise[SRC_EW] | src_fall[SRC_EW] |
                           src_rise[SRC_BO] | src_fall[SRC_BO]) & int_en[BIT_EW];
        set_req[BIT_DO] = src_rise[SRC_OV] & int_en[BIT_DO];
        set_req[BIT_WU] = sleeping & bus_activity & int_en[BIT_WU];
        set_req[BIT_EP] = (src_rise[SRC_EP] | src_fall[SRC_EP]) & int_en[BIT_EP];
        set_req[BIT_AL] = arb_lost & int_en[BIT_AL];
        set_req[BIT_BE] = bus_err & int_en[BIT_BE];
    end

    can_icr_flags #(.N(FLAG_TOP)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rd_en),
        .set  (set_req),
        .flags(flags_q)
    );

    can_icr_capture #(.W(CAP_W)) u_cap_be (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (bus_err),
        .code (bus_err_code),
        .rd   (rd_en),
        .val  (be_val),
        .armed(be_armed)
    );

    can_icr_capture #(.W(CAP_W)) u_cap_al (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (arb_lost),
        .code (arb_lost_pos),
        .rd   (rd_en),
        .val  (al_val),
        .armed(al_armed)
    );

    // assemble word and combined request
    always_comb begin
        ri      = rx_buf_full & int_en[BIT_RI];
        rd_data = {al_val, be_val, {ZERO_W{1'b0}}, flags_q, ri};
        irq     = ri | (|flags_q);
    end
endmodule

// File: rtl/can_icr_checker.sv
// Property checker for can_irq_capture, attached through bind.
module can_icr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        irq,
    input logic        rx_buf_full,
    input logic        tx_buf1_free,
    input logic        overrun,
    input logic        bus_err,
    input logic        arb_lost,
    input logic        en_ri,
    input logic        en_ti,
    input logic        en_al,
    input logic        en_be,
    input logic        be_armed,
    input logic        al_armed
);
    assert_ri_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_buf_full && en_ri) |-> (rd_data[0] && irq));

    assert_tx_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_buf1_free) && en_ti) |=> rd_data[1]);

    assert_al_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && en_al) |=> rd_data[6]);

    assert_be_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !be_armed) |=> $stable(rd_data[23:16]));

    assert_al_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !al_armed) |=> $stable(rd_data[31:24]));

    assert_be_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !bus_err) |=> be_armed);

    assert_ov_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !overrun) |=> !rd_data[3]);

    assert_zero_field_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:8] == 8'h00);

    assert_read_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_err && en_be) |=> (rd_data[7] && !be_armed));

    assert_irq_or_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|rd_data[10:0]));
endmodule

bind can_irq_capture can_icr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .irq         (irq),
    .rx_buf_full (rx_buf_full),
    .tx_buf1_free(tx_buf1_free),
    .overrun     (overrun),
    .bus_err     (bus_err),
    .arb_lost    (arb_lost),
    .en_ri       (int_en[0]),
    .en_ti       (int_en[1]),
    .en_al       (int_en[6]),
    .en_be       (int_en[7]),
    .be_armed    (be_armed),
    .al_armed    (al_armed)
);

// File: tb/can_irq_capture_test.sv
`timescale 1ns/1ps
module can_irq_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        rx_buf_full = 1'b0, tx_buf1_free = 1'b0, err_warn = 1'b0;
    logic        bus_off = 1'b0, overrun = 1'b0, sleeping = 1'b0;
    logic        bus_activity = 1'b0, err_passive = 1'b0;
    logic        bus_err = 1'b0, arb_lost = 1'b0;
    logic [7:0]  bus_err_code = 8'h00, arb_lost_pos = 8'h00, int_en = 8'h00;
    logic [31:0] rd_data;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference model state
    logic [10:1] m_flags = '0;
    logic [7:0]  m_be = '0, m_al = '0;
    bit          m_be_arm = 1, m_al_arm = 1;
    logic        p_tx = 0, p_ew = 0, p_bo = 0, p_ov = 0, p_ep = 0;

    always #2.5 clk = ~clk;

    can_irq_capture uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .rx_buf_full(rx_buf_full), .tx_buf1_free(tx_buf1_free),
        .err_warn(err_warn), .bus_off(bus_off), .overrun(overrun),
        .sleeping(sleeping), .bus_activity(bus_activity),
        .err_passive(err_passive), .bus_err(bus_err),
        .bus_err_code(bus_err_code), .arb_lost(arb_lost),
        .arb_lost_pos(arb_lost_pos), .int_en(int_en),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every field of the word against the model
    task automatic compare_all();
        logic ri;
        ri = rx_buf_full & int_en[0];
        chk("R2 receive level bit0", 32'(rd_data[0]), 32'(ri));
        chk("R3 transmit bit1", 32'(rd_data[1]), 32'(m_flags[1]));
        chk("R4 status change bit2", 32'(rd_data[2]), 32'(m_flags[2]));
        chk("R5 overrun bit3", 32'(rd_data[3]), 32'(m_flags[3]));
        chk("R6 wake-up bit4", 32'(rd_data[4]), 32'(m_flags[4]));
        chk("R7 error passive bit5", 32'(rd_data[5]), 32'(m_flags[5]));
        chk("R9 arbitration bit6", 32'(rd_data[6]), 32'(m_flags[6]));
        chk("R8 bus error bit7", 32'(rd_data[7]), 32'(m_flags[7]));
        chk("R11 bits15:8 zero", 32'(rd_data[15:8]), 32'h0);
        chk("R8 R10 error capture byte", 32'(rd_data[23:16]), 32'(m_be));
        chk("R9 R10 arbitration capture byte", 32'(rd_data[31:24]), 32'(m_al));
        chk("R13 combined request", 32'(irq), 32'(ri | (|m_flags)));
    endtask

    // advance the model by one clock using the inputs of this cycle
    task automatic model_update();
        logic [10:1] s;
        s = '0;
        if (tx_buf1_free && !p_tx && int_en[1]) s[1] = 1;
        if (((err_warn != p_ew) || (bus_off != p_bo)) && int_en[2]) s[2] = 1;
        if (overrun && !p_ov && int_en[3]) s[3] = 1;
        if (sleeping && bus_activity && int_en[4]) s[4] = 1;
        if ((err_passive != p_ep) && int_en[5]) s[5] = 1;
        if (arb_lost && int_en[6]) s[6] = 1;
        if (bus_err && int_en[7]) s[7] = 1;
        if (rd_en) m_flags = s;
        else       m_flags = m_flags | s;
        if (bus_err && (m_be_arm || rd_en)) begin
            m_be = bus_err_code; m_be_arm = 0;
        end else if (rd_en) m_be_arm = 1;
        if (arb_lost && (m_al_arm || rd_en)) begin
            m_al = arb_lost_pos; m_al_arm = 0;
        end else if (rd_en) m_al_arm = 1;
        p_tx = tx_buf1_free; p_ew = err_warn; p_bo = bus_off;
        p_ov = overrun; p_ep = err_passive;
    endtask

    // one cycle: inputs are already set at a falling edge
    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic rd_tick();
        rd_en = 1; tick(); rd_en = 0;
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 reset request", 32'(irq), 32'h0);
        rst_n = 1;
        int_en = 8'hFF;
        tick();
        // R2 level receive flag survives a read
        rx_buf_full = 1; tick(); rd_tick(); tick();
        rx_buf_full = 0; tick();
        // R3 edge only, R11 read clear while level persists
        tx_buf1_free = 1; tick(); tick(); rd_tick(); tick();
        tx_buf1_free = 0; tick(); tick();
        // R4 both edges of both sources
        err_warn = 1; tick(); rd_tick(); err_warn = 0; tick(); rd_tick();
        bus_off = 1; tick(); rd_tick(); bus_off = 0; tick(); rd_tick();
        int_en[2] = 0; err_warn = 1; tick(); tick(); int_en[2] = 1; tick();
        err_warn = 0; tick(); rd_tick();
        // R5 overrun
        overrun = 1; tick(); tick(); rd_tick(); overrun = 0; tick();
        // R6 wake-up needs both conditions
        sleeping = 1; tick(); bus_activity = 1; tick(); sleeping = 0;
        bus_activity = 0; rd_tick(); tick();
        // R7 both directions
        err_passive = 1; tick(); rd_tick(); err_passive = 0; tick(); rd_tick();
        // R8 R10 capture freezes on first error
        bus_err = 1; bus_err_code = 8'hA5; tick();
        bus_err_code = 8'h3C; tick(); bus_err = 0; tick();
        rd_tick(); tick();
        bus_err = 1; bus_err_code = 8'h5A; tick(); bus_err = 0; tick();
        // R9 arbitration capture
        arb_lost = 1; arb_lost_pos = 8'h11; tick();
        arb_lost_pos = 8'h22; tick(); arb_lost = 0; tick();
        // R12 event in the same cycle as a read
        bus_err = 1; bus_err_code = 8'h77; arb_lost = 1; arb_lost_pos = 8'h1F;
        overrun = 1; rd_tick();
        bus_err = 0; arb_lost = 0; overrun = 0; tick(); rd_tick(); tick();
        // disabled capture still loads, flag stays clear
        int_en = 8'h00; bus_err = 1; bus_err_code = 8'hC3; tick();
        bus_err = 0; tick(); int_en = 8'hFF; rd_tick(); tick();
        // random mix
        for (int i = 0; i < 4000; i++) begin
            rx_buf_full  = ($urandom_range(0, 3) == 0);
            tx_buf1_free = ($urandom_range(0, 5) == 0) ? ~tx_buf1_free : tx_buf1_free;
            err_warn     = ($urandom_range(0, 7) == 0) ? ~err_warn : err_warn;
            bus_off      = ($urandom_range(0, 9) == 0) ? ~bus_off : bus_off;
            overrun      = ($urandom_range(0, 5) == 0) ? ~overrun : overrun;
            sleeping     = ($urandom_range(0, 3) == 0);
            bus_activity = ($urandom_range(0, 3) == 0);
            err_passive  = ($urandom_range(0, 9) == 0) ? ~err_passive : err_passive;
            bus_err      = ($urandom_range(0, 7) == 0);
            bus_err_code = 8'($urandom);
            arb_lost     = ($urandom_range(0, 7) == 0);
            arb_lost_pos = 8'($urandom);
            rd_en        = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 49) == 0) int_en = 8'($urandom);
            tick();
        end
        rd_en = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule